// File: doc/BRIEF.md
# SD write CRC status checker

After the host finishes sending a write data block, the SD card replies on DAT0 with a short status token and then holds DAT0 low while it programs the block. This block follows that exchange. It ignores a fixed guard gap after the host's block, waits for the token's start bit, collects the status bits and the closing bit, and then watches the busy period until the card releases the line. Every stage has its own limit. The host learns how the block ended from a small set of one-cycle result pulses.

DAT0 arrives already sampled. The block acts only in system-clock cycles where the SD-clock enable is high. The host pulses `start_i` once after it drives its own end bit. It then reads `done_o` together with at most one error flag. While the card signals busy, `busy_o` stays high.

Top module: `sd_wcrc_status_chk`

## Requirements
- R1: While reset is low, and after it, all result pulses and `busy_o` are 0.
- R2: After `start_i` is taken, the first two SD-clock ticks are ignored whatever DAT0 is. A 0 on one of them is not a start bit.
- R3: While waiting for the start bit, each tick with DAT0=1 is counted. The tick that would make the count exceed `wait_limit_i` raises `timeout_err_o` with `done_o`. Exactly `wait_limit_i` high ticks are allowed.
- R4: The token is a start bit of 0, then three status bits with the MSB first, then an end bit. Status value 3'b010 with end bit 1 is accepted and leads to the busy stage.
- R5: A status value other than 3'b010 raises `crc_err_o` with `done_o` on the end-bit tick. This takes priority over a bad end bit.
- R6: A valid status value with a 0 on the end-bit tick raises `endbit_err_o` with `done_o`.
- R7: `busy_o` is high from the end-bit tick of an accepted token until the busy stage ends.
- R8: In the busy stage, the tick that would make the count of DAT0=0 ticks exceed `busy_limit_i` raises `timeout_err_o` with `done_o`.
- R9: A busy-stage tick with DAT0=1 gives `done_o` with no error flag. This includes the first busy tick.
- R10: Each block produces exactly one `done_o` pulse, one clock long. Every error pulse coincides with `done_o`, and at most one error flag is high.
- R11: Once the result is reported, DAT0 is ignored until the next `start_i`. A `start_i` while a block is in progress is ignored.
- R12: DAT0 and the counters are only considered in cycles with `sd_ce_i` high. Results appear one clock after the deciding tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_ce_i | input | 1 | SD-clock enable: DAT0 sample valid this cycle |
| dat0_i | input | 1 | Sampled DAT0 line |
| start_i | input | 1 | Pulse after the host's write end bit |
| wait_limit_i | input | WAIT_W | Allowed high ticks before the token start bit |
| busy_limit_i | input | BUSY_W | Allowed busy (low) ticks after the token |
| done_o | output | 1 | One-cycle pulse: block result available |
| crc_err_o | output | 1 | One-cycle pulse: status value not 3'b010 |
| endbit_err_o | output | 1 | One-cycle pulse: token end bit was 0 |
| timeout_err_o | output | 1 | One-cycle pulse: start-bit wait or busy too long |
| busy_o | output | 1 | Card is holding DAT0 low after an accepted token |

## Verification
Token patterns cover the good value, random bad values and a bad value with a bad end bit. Together they separate the CRC path, the end-bit path and the priority between them. The wait and busy lengths are drawn around their limits, including exactly at the limit and one past it, so an off-by-one in either counter shows up as a misplaced or missing timeout. The gap ticks carry random values, including zeros, to expose a design that takes a gap bit as a start bit. DAT0 toggles in cycles with the enable low and after each result, and a second start pulse lands on the start-bit tick, to confirm those inputs change nothing.

// File: rtl/sdwc_pkg.sv
// Shared types for the SD write CRC status checker.
// Assumes: used by all sdwc_* modules and by sd_wcrc_status_chk.
package sdwc_pkg;

    // Phases of one write-status exchange.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_TOKEN = 3'd3,
        ST_ENDB  = 3'd4,
        ST_BUSY  = 3'd5
    } sdwc_state_e;

    // Kinds of result a block can end with.
    typedef enum logic [1:0] {
        OUT_PASS    = 2'd0,
        OUT_CRC     = 2'd1,
        OUT_ENDBIT  = 2'd2,
        OUT_TIMEOUT = 2'd3
    } sdwc_outcome_e;

endpackage

// File: rtl/sdwc_limit_counter.sv
// Tick counter with a compare against a programmable limit.
// Assumes: the caller never increments past the limit (it acts on at_limit first),
// so the count cannot wrap; clr has priority over inc.
module sdwc_limit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         at_limit
);

    logic [W-1:0] cnt_q;

    // Hold, clear or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit reached: the next counted event is one too many.
    assign at_limit = (cnt_q == limit);

endmodule

// File: rtl/sdwc_token_sreg.sv
// Collects the status bits of the token, first bit ending up as the MSB.
// Assumes: TOK_W >= 1; clr is applied before each token; shift_en pulses once per bit.
module sdwc_token_sreg #(
    parameter int TOK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [TOK_W-1:0] token,
    output logic             last_bit
);

    localparam int IW = (TOK_W > 1) ? $clog2(TOK_W) : 1;

    logic [TOK_W-1:0] tok_q;
    logic [TOK_W-1:0] tok_nxt;
    logic [IW-1:0]    idx_q;

    // New value after shifting in one bit at the LSB end.
    always_comb begin
        tok_nxt = (tok_q << 1) | TOK_W'(bit_in);
    end

    // Shift register and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            tok_q <= '0;
            idx_q <= '0;
        end else if (shift_en) begin
            tok_q <= tok_nxt;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign token    = tok_q;
    assign last_bit = (idx_q == IW'(TOK_W - 1));

endmodule

// File: rtl/sdwc_report_reg.sv
// Turns a one-cycle result strobe and its kind into registered output pulses.
// Assumes: fire is high for a single cycle per block.
module sdwc_report_reg
    import sdwc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  sdwc_outcome_e outcome,
    output logic          done_o,
    output logic          crc_o,
    output logic          endbit_o,
    output logic          timeout_o
);

    // Pulse done with at most one error flag, for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            crc_o     <= 1'b0;
            endbit_o  <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            done_o    <= fire;
            crc_o     <= fire && (outcome == OUT_CRC);
            endbit_o  <= fire && (outcome == OUT_ENDBIT);
            timeout_o <= fire && (outcome == OUT_TIMEOUT);
        end
    end

endmodule

// File: rtl/sd_wcrc_status_chk.sv
// Write CRC status checker: after start_i it skips GAP_TICKS SD ticks, waits for
// the token start bit (bounded by wait_limit_i), gathers TOK_W status bits and
// the end bit, then monitors card busy (bounded by busy_limit_i).
// Assumes: dat0_i is already synchronised; limits are stable during a block;
// GAP_TICKS >= 1.
module sd_wcrc_status_chk
    import sdwc_pkg::*;
#(
    parameter int               TOK_W      = 3,
    parameter logic [TOK_W-1:0] TOKEN_GOOD = TOK_W'(2),
    parameter int               GAP_TICKS  = 2,
    parameter int               WAIT_W     = 16,
    parameter int               BUSY_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_ce_i,
    input  logic              dat0_i,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] wait_limit_i,
    input  logic [BUSY_W-1:0] busy_limit_i,
    output logic              done_o,
    output logic              crc_err_o,
    output logic              endbit_err_o,
    output logic              timeout_err_o,
    output logic              busy_o
);

    localparam int GAP_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

    sdwc_state_e      st_q, st_nxt;
    sdwc_outcome_e    outcome;
    logic             fire;
    logic             gap_clr, gap_inc, gap_last;
    logic             wait_clr, wait_inc, wait_expired;
    logic             busy_clr, busy_inc, busy_expired;
    logic             tok_clr, tok_shift, tok_last;
    logic [TOK_W-1:0] token;

    sdwc_limit_counter #(.W(GAP_W)) u_gap_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (gap_clr),
        .inc      (gap_inc),
        .limit    (GAP_W'(GAP_TICKS - 1)),
        .at_limit (gap_last)
    );

    sdwc_limit_counter #(.W(WAIT_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wait_clr),
        .inc      (wait_inc),
        .limit    (wait_limit_i),
        .at_limit (wait_expired)
    );

    sdwc_limit_counter #(.W(BUSY_W)) u_busy_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (busy_clr),
        .inc      (busy_inc),
        .limit    (busy_limit_i),
        .at_limit (busy_expired)
    );

    sdwc_token_sreg #(.TOK_W(TOK_W)) u_token (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tok_clr),
        .shift_en (tok_shift),
        .bit_in   (dat0_i),
        .token    (token),
        .last_bit (tok_last)
    );

    sdwc_report_reg u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .outcome   (outcome),
        .done_o    (done_o),
        .crc_o     (crc_err_o),
        .endbit_o  (endbit_err_o),
        .timeout_o (timeout_err_o)
    );

    // Next phase, counter controls and result strobe for this cycle.
    always_comb begin
        st_nxt    = st_q;
        fire      = 1'b0;
        outcome   = OUT_PASS;
        gap_clr   = 1'b0;
        gap_inc   = 1'b0;
        wait_clr  = 1'b0;
        wait_inc  = 1'b0;
        busy_clr  = 1'b0;
        busy_inc  = 1'b0;
        tok_clr   = 1'b0;
        tok_shift = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_nxt   = ST_GAP;
                    gap_clr  = 1'b1;
                    wait_clr = 1'b1;
                    tok_clr  = 1'b1;
                end
            end
            ST_GAP: begin
                if (sd_ce_i) begin
                    if (gap_last) begin
                        st_nxt = ST_WAIT;
                    end else begin
                        gap_inc = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (sd_ce_i) begin
                    if (!dat0_i) begin
                        st_nxt = ST_TOKEN;
                    end else if (wait_expired) begin
                        st_nxt  = ST_IDLE;
                        fire    = 1'b1;
                        outcome = OUT_TIMEOUT;
                    end else begin
                        wait_inc = 1'b1;
                    end
                end
            end
            ST_TOKEN: begin
                if (sd_ce_i) begin
                    tok_shift = 1'b1;
                    if (tok_last) begin
                        st_nxt = ST_ENDB;
                    end
                end
            end
            ST_ENDB: begin
                if (sd_ce_i) begin
                    if (token != TOKEN_GOOD) begin
                        st_nxt  = ST_IDLE;
                        fire    = 1'b1;
                        outcome = OUT_CRC;
                    end else if (!dat0_i) begin
                        st_nxt  = ST_IDLE;
                        fire    = 1'b1;
                        outcome = OUT_ENDBIT;
                    end else begin
                        st_nxt   = ST_BUSY;
                        busy_clr = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (sd_ce_i) begin
                    if (dat0_i) begin
                        st_nxt  = ST_IDLE;
                        fire    = 1'b1;
                        outcome = OUT_PASS;
                    end else if (busy_expired) begin
                        st_nxt  = ST_IDLE;
                        fire    = 1'b1;
                        outcome = OUT_TIMEOUT;
                    end else begin
                        busy_inc = 1'b1;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    assign busy_o = (st_q == ST_BUSY);

endmodule

// File: rtl/sd_wcrc_status_chk_sva.sv
// Property checker for sd_wcrc_status_chk, attached by bind below.
// Assumes: observes ports only.
module sd_wcrc_status_chk_sva (
    input logic clk,
    input logic rst_n,
    input logic sd_ce_i,
    input logic dat0_i,
    input logic done_o,
    input logic crc_err_o,
    input logic endbit_err_o,
    input logic timeout_err_o,
    input logic busy_o
);

    AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_o || endbit_err_o || timeout_err_o) |-> done_o); // R10

    AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crc_err_o, endbit_err_o, timeout_err_o})); // R10

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_BUSY_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ce_i |=> $stable(busy_o)); // R12

    AST_RESULT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sd_ce_i)); // R12

    AST_PASS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !timeout_err_o && $past(busy_o)) |-> $past(dat0_i)); // R9

endmodule

bind sd_wcrc_status_chk sd_wcrc_status_chk_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .sd_ce_i       (sd_ce_i),
    .dat0_i        (dat0_i),
    .done_o        (done_o),
    .crc_err_o     (crc_err_o),
    .endbit_err_o  (endbit_err_o),
    .timeout_err_o (timeout_err_o),
    .busy_o        (busy_o)
);

// File: tb/sd_wcrc_status_chk_test.sv
module sd_wcrc_status_chk_test;

    localparam int WAIT_W = 16;
    localparam int BUSY_W = 20;
    // Observation vector {done, crc, endbit, timeout, busy}
    localparam logic [4:0] E_NONE = 5'b00000;
    localparam logic [4:0] E_BUSY = 5'b00001;
    localparam logic [4:0] E_TO   = 5'b10010;
    localparam logic [4:0] E_EB   = 5'b10100;
    localparam logic [4:0] E_CRC  = 5'b11000;
    localparam logic [4:0] E_DONE = 5'b10000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, sd_ce, dat0, start;
    logic [WAIT_W-1:0] wl;
    logic [BUSY_W-1:0] bl;
    logic              done_o, crc_err_o, endbit_err_o, timeout_err_o, busy_o;

    int total = 0;
    int bad = 0;
    int done_seen = 0;
    int blocks = 0;
    bit finished = 0;

    sd_wcrc_status_chk #(.WAIT_W(WAIT_W), .BUSY_W(BUSY_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sd_ce_i       (sd_ce),
        .dat0_i        (dat0),
        .start_i       (start),
        .wait_limit_i  (wl),
        .busy_limit_i  (bl),
        .done_o        (done_o),
        .crc_err_o     (crc_err_o),
        .endbit_err_o  (endbit_err_o),
        .timeout_err_o (timeout_err_o),
        .busy_o        (busy_o)
    );

    // Count every done pulse over the whole run (R10).
    always @(negedge clk) if (rst_n && done_o) done_seen++;

    task automatic check(string req, logic [4:0] act, logic [4:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One SD tick; DAT0 toggles in the idle cycles that follow (R12).
    task automatic one_tick(bit b, bit with_start, output logic [4:0] obs);
        @(negedge clk);
        sd_ce = 1'b1; dat0 = b; start = with_start;
        @(negedge clk);
        sd_ce = 1'b0; start = 1'b0;
        obs = {done_o, crc_err_o, endbit_err_o, timeout_err_o, busy_o};
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            dat0 = 1'($urandom_range(0, 1));
        end
    endtask

    // Expected per-tick observations built from the requirements.
    task automatic run_block(int wlim, int blim, int h, logic [2:0] tok, bit eb,
                             int b, bit [1:0] g, bit restart_mid);
        bit         sq[$];
        logic [4:0] ex[$];
        string      tg[$];
        bit         stop = 0;
        int         sb_idx = -1;
        wl = WAIT_W'(wlim);
        bl = BUSY_W'(blim);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        sq.push_back(g[1]); ex.push_back(E_NONE); tg.push_back("R2");
        sq.push_back(g[0]); ex.push_back(E_NONE); tg.push_back("R2");
        for (int k = 0; k < h && !stop; k++) begin
            sq.push_back(1'b1);
            if (k == wlim) begin ex.push_back(E_TO); tg.push_back("R3"); stop = 1; end
            else begin ex.push_back(E_NONE); tg.push_back("R3"); end
        end
        if (!stop) begin
            sb_idx = sq.size();
            sq.push_back(1'b0); ex.push_back(E_NONE); tg.push_back("R4");
            for (int j = 2; j >= 0; j--) begin
                sq.push_back(tok[j]); ex.push_back(E_NONE); tg.push_back("R4");
            end
            sq.push_back(eb);
            if (tok != 3'b010) begin ex.push_back(E_CRC); tg.push_back("R5"); stop = 1; end
            else if (!eb) begin ex.push_back(E_EB); tg.push_back("R6"); stop = 1; end
            else begin ex.push_back(E_BUSY); tg.push_back("R7"); end
        end
        for (int k = 0; k < b && !stop; k++) begin
            sq.push_back(1'b0);
            if (k == blim) begin ex.push_back(E_TO); tg.push_back("R8"); stop = 1; end
            else begin ex.push_back(E_BUSY); tg.push_back("R7"); end
        end
        if (!stop) begin sq.push_back(1'b1); ex.push_back(E_DONE); tg.push_back("R9"); end
        for (int k = 0; k < 3; k++) begin
            sq.push_back(1'($urandom_range(0, 1))); ex.push_back(E_NONE); tg.push_back("R11");
        end
        for (int i = 0; i < sq.size(); i++) begin
            logic [4:0] o;
            one_tick(sq[i], restart_mid && (i == sb_idx), o);
            check(tg[i], o, ex[i], $sformatf("block %0d tick %0d", blocks, i));
        end
        blocks++;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sd_ce = 1'b0; dat0 = 1'b1; start = 1'b0; wl = '0; bl = '0;
        repeat (3) @(negedge clk);
        check("R1", {done_o, crc_err_o, endbit_err_o, timeout_err_o, busy_o}, E_NONE, "in reset");
        rst_n = 1'b1;
        // R11: ticks with DAT0 low before any start produce nothing
        for (int i = 0; i < 4; i++) begin
            logic [4:0] o;
            one_tick(1'b0, 1'b0, o);
            check("R11", o, E_NONE, "idle tick");
        end
        // Directed corners
        run_block(3, 3, 0, 3'b010, 1, 0, 2'b11, 0);  // R9 immediate release
        run_block(0, 3, 1, 3'b010, 1, 0, 2'b11, 0);  // R3 zero wait limit
        run_block(4, 3, 4, 3'b010, 1, 2, 2'b00, 0);  // R3 exactly at limit, R2 zero gap bits
        run_block(4, 3, 5, 3'b010, 1, 2, 2'b10, 0);  // R3 one past limit
        run_block(2, 0, 0, 3'b010, 1, 1, 2'b11, 0);  // R8 zero busy limit
        run_block(2, 3, 0, 3'b010, 1, 3, 2'b01, 0);  // R8 busy exactly at limit
        run_block(2, 3, 0, 3'b010, 1, 4, 2'b11, 0);  // R8 one past
        run_block(2, 3, 1, 3'b111, 1, 0, 2'b11, 0);  // R5
        run_block(2, 3, 1, 3'b000, 0, 0, 2'b11, 0);  // R5 priority over end bit
        run_block(2, 3, 1, 3'b010, 0, 0, 2'b11, 0);  // R6
        run_block(2, 3, 2, 3'b010, 1, 2, 2'b11, 1);  // R11 start mid-block ignored
        // Constrained random blocks
        for (int n = 0; n < 150; n++) begin
            logic [2:0] tk;
            tk = ($urandom_range(0, 1) == 0) ? 3'b010 : 3'($urandom_range(0, 7));
            run_block($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 8), tk,
                      ($urandom_range(0, 6) != 0), $urandom_range(0, 8),
                      2'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0));
        end
        repeat (3) @(negedge clk);
        check("R10", 5'(done_seen), 5'(blocks), "done pulses vs blocks");
        total++;
        if (done_seen != blocks) begin
            bad++;
            $display("FAIL R10 done count: actual=%0d expected=%0d", done_seen, blocks);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule